// File: doc/BRIEF.md
# Replay Transmit FIFO with Parity

This block is the elastic store between a bus-side producer of frame bytes and a transmit-side consumer that runs on its own clock. It holds up to 80 bytes, each stored with an even-parity bit. It keeps the opening 64 bytes of the frame in progress so the transmitter can start the frame over after a collision without asking the bus side for those bytes again. The remaining 16 entries absorb bus latency while a frame streams out.

The write side asks for data whenever it sees room. Its view of the used space is bounded by a release pointer that the read side sends across the clock boundary. The read side raises a start handshake once enough bytes are stored to meet a programmable threshold. Each byte read is checked for parity. A mismatch latches an error, can raise an interrupt, and stops further reads. Pointers cross between the clocks in Gray code through two-flop synchronizers. The release pointer moves one step per read clock, so it never changes more than one bit at a time.

Top module: `rtx_fifo`

## Requirements
- R1: After reset, `empty` and `wr_req` are high, while `tx_ready`, `rd_valid`, `par_err`, `late_col` and `err_irq` are low.
- R2: Bytes come out in the order they were written. A read accepted on an `rclk` edge sets `rd_valid` and `rd_data` on that same edge, so they are visible for the following cycle.
- R3: The store holds exactly 80 bytes. `wr_req` is low while 80 bytes of unreleased data are held, and a write made while `wr_req` is low is dropped.
- R4: A read request while `empty` is high is ignored, and `rd_valid` stays low.
- R5: `tx_ready` is high exactly when the byte count seen on the read side is at least `thresh`. This holds once the write pointer has crossed to the read side.
- R6: A `rewind` pulse while fewer than 64 bytes of the current frame have been read returns reading to the first byte of the frame. That byte and the ones after it are then replayed.
- R7: Once 64 bytes of the current frame have been read, `rewind` has no effect on the read position and sets the sticky `late_col` flag.
- R8: `frame_done` makes the current read position the start of the next frame. Released entries reach the write side, which raises `wr_req` again.
- R9: Each stored word carries even parity over 9 bits. `wr_bad_par` inverts the stored parity bit for that write. Reading a word with odd parity sets the sticky `par_err`, and `err_irq` equals `par_err` AND `err_irq_en`.
- R10: While `par_err` is set, read requests are ignored, so the faulty byte is the last one delivered.
- R11: The release pointer sent to the write side changes by at most one Gray bit per `rclk` cycle.
- R12: A `rewind` or `frame_done` pulse in a cycle takes precedence over a read request in that cycle, and the read is not performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Bus-side clock |
| wrst_n | input | 1 | Bus-side reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to store |
| wr_bad_par | input | 1 | Invert stored parity for this write (fault injection) |
| wr_req | output | 1 | Room available, more data wanted |
| rclk | input | 1 | Transmit-side clock |
| rrst_n | input | 1 | Transmit-side reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | 8 | Byte read out |
| rd_valid | output | 1 | `rd_data` holds a byte from the last cycle's read |
| thresh | input | 8 | Start threshold in bytes |
| tx_ready | output | 1 | Stored count has reached the threshold |
| empty | output | 1 | No unread byte on the read side |
| rewind | input | 1 | Collision: restart the frame |
| frame_done | input | 1 | Frame finished: release its entries |
| err_irq_en | input | 1 | Parity interrupt enable |
| par_err | output | 1 | Sticky parity error |
| late_col | output | 1 | Sticky rewind-after-release flag |
| err_irq | output | 1 | Parity interrupt |

## Verification
The hardest case to reach is the release boundary. A rewind must still work after 63 bytes of a frame have been read, and it must be refused after 64. The full condition is also hard to reach, because the write side only sees room once released entries have crossed back to it. A directed test writes a 70-byte frame, reads exactly 63 bytes, rewinds, replays the whole frame past the 64th byte, and then rewinds again. A second directed test fills all 80 entries with no release pending and tries one extra write. The random frames stay under 64 bytes and rewind at random points, so the replay path is exercised many times.

// File: rtl/rtx_fifo.sv
module rtx_fifo #(
  parameter int DEPTH  = 80,
  parameter int REPLAY = 64,
  parameter int DW     = 8,
  parameter int CW     = $clog2(DEPTH) + 1
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_bad_par,
  output logic          wr_req,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic [CW-1:0] thresh,
  output logic          tx_ready,
  output logic          empty,
  input  logic          rewind,
  input  logic          frame_done,
  input  logic          err_irq_en,
  output logic          par_err,
  output logic          late_col,
  output logic          err_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [CW-1:0] g2b(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW:0]   mem [DEPTH];

  logic [AW-1:0] waddr;
  logic [CW-1:0] wseq, wgray, fs1, fs2, wcount;
  logic          wput;

  assign wcount = wseq - g2b(fs2);
  assign wr_req = wcount < CW'(DEPTH);
  assign wput   = wr_en & wr_req;

  always_ff @(posedge wclk)
    if (wput) mem[waddr] <= {^wr_data ^ wr_bad_par, wr_data};

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      waddr <= '0; wseq <= '0; wgray <= '0; fs1 <= '0; fs2 <= '0;
    end else begin
      fs1 <= fgray; fs2 <= fs1;
      wgray <= wseq ^ (wseq >> 1);
      if (wput) begin
        waddr <= (waddr == LAST) ? '0 : waddr + 1'b1;
        wseq  <= wseq + 1'b1;
      end
    end

  logic [AW-1:0] raddr, baddr;
  logic [CW-1:0] rseq, bseq, fseq, fgray, ws1, ws2, avail, target;
  logic [DW:0]   word;
  logic          released, rget;

  assign avail    = g2b(ws2) - rseq;
  assign empty    = avail == '0;
  assign tx_ready = avail >= thresh;
  assign released = (rseq - bseq) >= CW'(REPLAY);
  assign target   = released ? rseq : bseq;
  assign rget     = rd_en & ~empty & ~par_err & ~frame_done & ~rewind;
  assign word     = mem[raddr];
  assign err_irq  = par_err & err_irq_en;

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      raddr <= '0; baddr <= '0; rseq <= '0; bseq <= '0; fseq <= '0; fgray <= '0;
      ws1 <= '0; ws2 <= '0; rd_data <= '0; rd_valid <= 1'b0;
      par_err <= 1'b0; late_col <= 1'b0;
    end else begin
      ws1 <= wgray; ws2 <= ws1;
      if (fseq != target) fseq <= fseq + 1'b1;
      fgray    <= fseq ^ (fseq >> 1);
      rd_valid <= rget;
      if (frame_done) begin
        baddr <= raddr; bseq <= rseq;
      end else if (rewind) begin
        if (released) late_col <= 1'b1;
        else begin raddr <= baddr; rseq <= bseq; end
      end else if (rget) begin
        raddr   <= (raddr == LAST) ? '0 : raddr + 1'b1;
        rseq    <= rseq + 1'b1;
        rd_data <= word[DW-1:0];
        if (^word) par_err <= 1'b1;
      end
    end

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    wcount <= CW'(DEPTH)); // R3
  AST_NO_UNDERREAD: assert property (@(posedge rclk) disable iff (!rrst_n)
    avail <= CW'(DEPTH)); // R4
  AST_REWIND_BASE: assert property (@(posedge rclk) disable iff (!rrst_n)
    rewind && !frame_done && !released |=> rseq == $past(bseq)); // R6
  AST_LATE_FLAG: assert property (@(posedge rclk) disable iff (!rrst_n)
    rewind && !frame_done && released |=> late_col && rseq == $past(rseq)); // R7
  AST_PERR_STICKY: assert property (@(posedge rclk) disable iff (!rrst_n)
    par_err |=> par_err); // R9
  AST_HALT_READS: assert property (@(posedge rclk) disable iff (!rrst_n)
    par_err |=> !rd_valid); // R10
  AST_ONE_BIT_STEP: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(fgray ^ $past(fgray)) <= 1); // R11
  AST_PULSE_WINS: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rewind || frame_done) |=> !rd_valid); // R12
endmodule

// File: tb/sim_rtx_fifo.sv
module sim_rtx_fifo;
  localparam int WPER = 10;
  localparam int RPER = 14;

  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic wr_en = 0, wr_bad_par = 0, rd_en = 0, rewind = 0, frame_done = 0, err_irq_en = 0;
  logic [7:0] wr_data = 0, thresh = 8'd8;
  logic [7:0] rd_data;
  logic wr_req, rd_valid, tx_ready, empty, par_err, late_col, err_irq;

  always #(WPER/2) wclk = ~wclk;
  always #(RPER/2) rclk = ~rclk;

  rtx_fifo u0 (.*);

  int checks = 0, fails = 0;
  bit finished = 0;
  byte frame [100];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ready(int cnt, int th);
    return (cnt >= th) ? 1 : 0;
  endfunction

  task automatic do_reset();
    wr_en = 0; rd_en = 0; rewind = 0; frame_done = 0; wr_bad_par = 0;
    wrst_n = 0; rrst_n = 0;
    repeat (4) @(negedge rclk);
    wrst_n = 1; rrst_n = 1;
    repeat (2) @(negedge rclk);
  endtask

  task automatic wr(byte d, bit bad);
    @(negedge wclk); wr_en = 1; wr_data = d; wr_bad_par = bad;
    @(negedge wclk); wr_en = 0; wr_bad_par = 0;
  endtask

  task automatic rd(output bit v, output byte d);
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0; v = rd_valid; d = rd_data;
  endtask

  task automatic pulse_rew();
    @(negedge rclk); rewind = 1;
    @(negedge rclk); rewind = 0;
  endtask

  task automatic pulse_done();
    @(negedge rclk); frame_done = 1;
    @(negedge rclk); frame_done = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  initial begin
    #(WPER * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    bit v; byte d; int n;
    void'($urandom(32'd1234));
    do_reset();
    chk("R1 empty", empty, 1); chk("R1 wr_req", wr_req, 1);
    chk("R1 tx_ready", tx_ready, 0); chk("R1 rd_valid", rd_valid, 0);
    chk("R1 par_err", par_err, 0); chk("R1 late_col", late_col, 0);
    chk("R1 err_irq", err_irq, 0);

    rd(v, d); chk("R4 read when empty", v, 0);

    // random frames under 64 bytes with random rewinds
    for (int f = 0; f < 25; f++) begin
      int len, th, cut;
      len = 1 + $urandom % 60;
      th  = 1 + $urandom % 60;
      thresh = 8'(th);
      for (int i = 0; i < len; i++) begin
        frame[i] = byte'($urandom);
        wr(frame[i], 0);
      end
      settle();
      chk("R5 tx_ready", tx_ready, exp_ready(len, th));
      cut = ($urandom % 2) ? int'($urandom % len) : -1;
      for (int i = 0; i < len; i++) begin
        if (i == cut) begin
          pulse_rew();
          for (int k = 0; k < i; k++) begin
            rd(v, d); chk("R6 replay byte", int'(d), int'(frame[k]));
          end
          cut = -1;
        end
        rd(v, d);
        chk("R2 valid", v, 1); chk("R2 order", int'(d), int'(frame[i]));
      end
      chk("R6 no late flag", late_col, 0);
      chk("R4 empty after frame", empty, 1);
      pulse_done();
    end

    // precedence of pulses over a read
    wr(8'h5a, 0); settle();
    @(negedge rclk); rd_en = 1; rewind = 1;
    @(negedge rclk); rd_en = 0; rewind = 0;
    chk("R12 read blocked by rewind", rd_valid, 0);
    rd(v, d); chk("R12 byte still there", int'(d), 8'h5a);
    pulse_done();

    // release boundary: 63 reads may rewind, 64 may not
    do_reset();
    for (int i = 0; i < 70; i++) begin frame[i] = byte'(i * 3 + 1); wr(frame[i], 0); end
    settle();
    for (int i = 0; i < 63; i++) rd(v, d);
    pulse_rew();
    chk("R6 rewind at 63", late_col, 0);
    for (int i = 0; i < 70; i++) begin
      rd(v, d); chk("R6 replay after 63", int'(d), int'(frame[i]));
    end
    pulse_rew();
    chk("R7 late_col", late_col, 1);
    rd(v, d); chk("R7 position kept", v, 0);

    // full: 80 bytes of unreleased data
    do_reset();
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge wclk);
      if (!wr_req) break;
      frame[n] = byte'($urandom); wr(frame[n], 0); n++;
    end
    chk("R3 capacity", n, 80);
    chk("R3 wr_req low", wr_req, 0);
    wr(8'hee, 0);
    settle();
    for (int i = 0; i < 80; i++) begin
      rd(v, d); chk("R3 content", int'(d), int'(frame[i]));
    end
    rd(v, d); chk("R3 dropped write", v, 0);
    repeat (200) @(negedge wclk);
    chk("R8 room after release", wr_req, 1);
    pulse_done();
    repeat (50) @(negedge wclk);
    chk("R8 all free", wr_req, 1);

    // frame_done frees short frame
    do_reset();
    for (int i = 0; i < 80; i++) wr(byte'(i), 0);
    chk("R8 full before done", wr_req, 0);
    settle();
    for (int i = 0; i < 10; i++) rd(v, d);
    pulse_done();
    repeat (60) @(negedge wclk);
    chk("R8 room after frame_done", wr_req, 1);

    // parity fault
    do_reset();
    wr(8'h11, 0); wr(8'h22, 1); wr(8'h33, 0);
    settle();
    rd(v, d); chk("R9 good byte no error", par_err, 0);
    rd(v, d);
    chk("R9 bad byte delivered", int'(d), 8'h22);
    chk("R9 par_err", par_err, 1);
    chk("R9 irq masked", err_irq, 0);
    err_irq_en = 1; #1;
    chk("R9 irq enabled", err_irq, 1);
    rd(v, d); chk("R10 reads halted", v, 0);
    chk("R9 sticky", par_err, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule